// File: doc/BRIEF.md
# Serial SRAM Slave Protocol Engine

This block is the device side of a serial byte-addressed memory. It runs on a system clock. Chip select, serial clock and two data lines are passed through a synchroniser, and the engine detects the serial clock edges from the synchronised copies. Each transaction opens with an 8-bit opcode. A read or write opcode is followed by a 16-bit address, then by a stream of data bytes to or from an internal synchronous RAM. A mode register sets how the address pointer moves from byte to byte. Two further opcodes switch the link between one-bit framing and two-bit framing.

The data lines come out as separate input, output and per-line output-enable signals, so the pad ring builds the tri-state buffers. The array depth is a parameter. When the array is smaller than the 16-bit address space, the address pointer is still 16 bits wide, but only its low bits select a RAM location.

Top module: `serial_sram_slave`

## Requirements
- R1: After reset both output enables are low, the link uses one-bit framing, and the mode register holds 0x40 (sequential).
- R2: A command is accepted only after chip select goes from deselected to selected, as seen after reset. If chip select is already low when reset is released, the engine ignores the bus until chip select has been high once.
- R3: In one-bit framing, data enters on line 0 and is sampled on rising serial clock edges. Data leaves on line 1 and changes after falling edges. Every field moves most significant bit first: opcode 0x03 reads and 0x02 writes, each followed by a 16-bit address.
- R4: Opcode 0x01 loads the mode register from the next byte, and opcode 0x05 returns the register on the next byte. Only bits 7:6 can be written. Bits 5:0 always read back as 0.
- R5: When mode bits 7:6 are 01 or 11, the pointer steps by one after every byte and wraps from 0xFFFF to 0x0000.
- R6: When mode bits 7:6 are 10, the pointer steps within its aligned 32-byte page and wraps from the last byte of the page to the first byte of the same page.
- R7: When mode bits 7:6 are 00, exactly one data byte is transferred. Further write bytes do not change the array, and further read clocks leave both output enables low.
- R8: A write byte goes into the array only once all eight of its bits have arrived. A byte cut short by deselection is dropped.
- R9: A write byte whose last bit edge reaches the engine in the same sampled cycle as the deselect is still stored.
- R10: An unknown opcode is ignored until deselection. It drives no output and changes neither the array, the mode register nor the framing.
- R11: Opcode 0x3B switches the link to two-bit framing, in which line 1 carries the upper bit of each pair. In this framing a read inserts one dummy byte after the address, with both enables low, before the data.
- R12: Opcode 0xFF, sent in whichever framing is active, returns the link to one-bit framing.
- R13: Output enables are high only during read-data and mode-read phases. In one-bit framing only line 1 is enabled (10). In two-bit framing both lines are enabled (11). Deselection releases both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low, asynchronous to clk |
| sck_i | input | 1 | Serial clock from the host, asynchronous to clk |
| dio_i | input | 2 | Data lines as seen at the pads |
| dio_o | output | 2 | Data driven onto the lines |
| dio_oe_o | output | 2 | Per-line output enable |

## Verification
Storing a completed write byte and closing the transaction on deselect can land in the same system-clock cycle. Both inputs pass through matched synchroniser stages, so if the bench raises chip select at the same moment as the eighth rising serial clock edge, the two events reach the engine in the same cycle. The bench then reads the location back in a new transaction and expects the new byte (R9). It also cuts a byte short after five bits and expects the old contents (R8). Every expected byte comes from a model array in the bench that follows the pointer rules of each mode.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
  localparam logic [7:0] OP_READ     = 8'h03;
  localparam logic [7:0] OP_WRITE    = 8'h02;
  localparam logic [7:0] OP_DUAL_ON  = 8'h3B;
  localparam logic [7:0] OP_DUAL_OFF = 8'hFF;
  localparam logic [7:0] OP_MODE_RD  = 8'h05;
  localparam logic [7:0] OP_MODE_WR  = 8'h01;

  localparam logic [1:0] STEP_BYTE = 2'b00;
  localparam logic [1:0] STEP_PAGE = 2'b10;

  localparam logic [7:0] MODE_RESET = 8'h40;

  typedef enum logic [3:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_WDATA, ST_RDUMMY,
    ST_RDATA, ST_MRD, ST_MWR, ST_SKIP
  } eng_state_t;
endpackage

// File: rtl/ssram_sync.sv
module ssram_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [1:0] din,
  output logic       sel,
  output logic       start,
  output logic       rise,
  output logic       fall,
  output logic [1:0] din_s
);
  localparam int W = 4;
  logic [STAGES-1:0][W-1:0] chain;
  logic [W-1:0] last;
  logic cs_n_p, sck_p;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= {cs_n, sck, din};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign last = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_p <= 1'b0;
      sck_p  <= 1'b0;
    end else begin
      cs_n_p <= last[3];
      sck_p  <= last[2];
    end
  end

  assign sel   = ~last[3];
  assign start = cs_n_p & ~last[3];
  assign rise  = ~sck_p & last[2];
  assign fall  = sck_p & ~last[2];
  assign din_s = last[1:0];
endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/ssram_engine.sv
module ssram_engine
  import ssram_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int PAGE_W = 5,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              start,
  input  logic              rise,
  input  logic              fall,
  input  logic [1:0]        din,
  input  logic [7:0]        rdata,
  output logic              we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        wdata,
  output logic [1:0]        dout,
  output logic [1:0]        oe
);
  localparam int CNT_W = $clog2(ADDR_W + 1);

  eng_state_t        state_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nx, step, unit_len;
  logic [ADDR_W-1:0] sh_q, sh_nx, ptr_q, ptr_inc;
  logic [7:0]        mode_q, osh_q, in_byte, byte_src;
  logic              dual_q, is_rd_q, unit_done, readout;

  assign step      = dual_q ? CNT_W'(2) : CNT_W'(1);
  assign unit_len  = (state_q == ST_ADDR) ? CNT_W'(ADDR_W) : CNT_W'(8);
  assign cnt_nx    = cnt_q + step;
  assign unit_done = rise && (state_q != ST_IDLE) && (cnt_nx == unit_len);
  assign sh_nx     = dual_q ? {sh_q[ADDR_W-3:0], din} : {sh_q[ADDR_W-2:0], din[0]};
  assign in_byte   = sh_nx[7:0];
  assign readout   = (state_q == ST_RDATA) || (state_q == ST_MRD);

  always_comb begin
    if (mode_q[7:6] == STEP_PAGE) begin
      ptr_inc = ptr_q;
      ptr_inc[PAGE_W-1:0] = ptr_q[PAGE_W-1:0] + 1'b1;
    end else begin
      ptr_inc = ptr_q + 1'b1;
    end
  end

  always_comb begin
    if (cnt_q == '0) byte_src = (state_q == ST_MRD) ? mode_q : rdata;
    else             byte_src = osh_q;
  end

  assign we       = unit_done && (state_q == ST_WDATA);
  assign wdata    = in_byte;
  assign mem_addr = ptr_q[MEM_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      mode_q  <= MODE_RESET;
      dual_q  <= 1'b0;
      is_rd_q <= 1'b0;
      osh_q   <= '0;
      dout    <= '0;
      oe      <= '0;
    end else begin
      if (rise && state_q != ST_IDLE) begin
        sh_q  <= sh_nx;
        cnt_q <= unit_done ? '0 : cnt_nx;
      end
      if (unit_done) begin
        case (state_q)
          ST_OPC: begin
            case (in_byte)
              OP_READ:     begin is_rd_q <= 1'b1; state_q <= ST_ADDR; end
              OP_WRITE:    begin is_rd_q <= 1'b0; state_q <= ST_ADDR; end
              OP_DUAL_ON:  begin dual_q <= 1'b1;  state_q <= ST_SKIP; end
              OP_DUAL_OFF: begin dual_q <= 1'b0;  state_q <= ST_SKIP; end
              OP_MODE_RD:  state_q <= ST_MRD;
              OP_MODE_WR:  state_q <= ST_MWR;
              default:     state_q <= ST_SKIP;
            endcase
          end
          ST_ADDR: begin
            ptr_q <= sh_nx;
            if (!is_rd_q)    state_q <= ST_WDATA;
            else if (dual_q) state_q <= ST_RDUMMY;
            else             state_q <= ST_RDATA;
          end
          ST_WDATA, ST_RDATA: begin
            ptr_q <= ptr_inc;
            if (mode_q[7:6] == STEP_BYTE) state_q <= ST_SKIP;
          end
          ST_RDUMMY: state_q <= ST_RDATA;
          ST_MWR: begin
            mode_q  <= {in_byte[7:6], 6'b0};
            state_q <= ST_SKIP;
          end
          ST_MRD:  state_q <= ST_SKIP;
          default: ;
        endcase
      end
      if (fall && readout) begin
        dout  <= dual_q ? byte_src[7:6] : {byte_src[7], 1'b0};
        osh_q <= dual_q ? {byte_src[5:0], 2'b00} : {byte_src[6:0], 1'b0};
        oe    <= dual_q ? 2'b11 : 2'b10;
      end else if (!readout) begin
        oe <= 2'b00;
      end
      if (!sel) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (start) begin
        state_q <= ST_OPC;
        cnt_q   <= '0;
      end
    end
  end

  // R13: a deselected engine releases both lines on the following cycle
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> (oe == 2'b00));

  // R13: one-bit framing never enables line 0
  a_r13_single_line1: assert property (@(posedge clk) disable iff (rst)
    !dual_q |-> !oe[0]);

  // R11: two-bit framing is only entered from opcode decode
  a_r11_dual_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(dual_q) |-> ($past(state_q) == ST_OPC));

  // R2: an accepted select edge leads into opcode collection
  a_r2_start_to_opcode: assert property (@(posedge clk) disable iff (rst)
    (start && sel) |=> (state_q == ST_OPC));

  // R8: each stored byte moves the pointer or closes the data phase
  a_r8_commit_advances: assert property (@(posedge clk) disable iff (rst)
    we |=> ((ptr_q != $past(ptr_q)) || (state_q == ST_SKIP) || (state_q == ST_IDLE)));
endmodule

// File: rtl/serial_sram_slave.sv
module serial_sram_slave #(
  parameter int MEM_AW      = 10,
  parameter int PAGE_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic [1:0] dio_i,
  output logic [1:0] dio_o,
  output logic [1:0] dio_oe_o
);
  logic              sel, start, rise, fall, we;
  logic [1:0]        din_s;
  logic [7:0]        rdata, wdata;
  logic [MEM_AW-1:0] mem_addr;

  ssram_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n_i), .sck(sck_i), .din(dio_i),
    .sel(sel), .start(start), .rise(rise), .fall(fall), .din_s(din_s)
  );

  ssram_engine #(.MEM_AW(MEM_AW), .PAGE_W(PAGE_W), .ADDR_W(16)) u_engine (
    .clk(clk), .rst(rst), .sel(sel), .start(start), .rise(rise), .fall(fall),
    .din(din_s), .rdata(rdata), .we(we), .mem_addr(mem_addr), .wdata(wdata),
    .dout(dio_o), .oe(dio_oe_o)
  );

  ssram_array #(.AW(MEM_AW), .DW(8)) u_array (
    .clk(clk), .we(we), .addr(mem_addr), .wdata(wdata), .rdata(rdata)
  );
endmodule

// File: tb/serial_sram_slave_bench.sv
module serial_sram_slave_bench;
  localparam int MAW = 8;
  localparam int DEPTH = 1 << MAW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b0;
  logic sck = 1'b0;
  logic [1:0] din = 2'b00;
  logic [1:0] dio_o, dio_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit tb_dual = 1'b0;
  logic [1:0] tb_mode = 2'b01;
  logic [7:0] mm [DEPTH];

  always #4 clk = ~clk;

  serial_sram_slave #(.MEM_AW(MAW), .PAGE_W(5), .SYNC_STAGES(2)) u_serial_sram_slave (
    .clk(clk), .rst(rst), .cs_n_i(sel_n), .sck_i(sck), .dio_i(din),
    .dio_o(dio_o), .dio_oe_o(dio_oe)
  );

  function automatic logic [7:0] pat(int x);
    return 8'((x * 37 + 11) & 255);
  endfunction

  function automatic logic [15:0] next_ptr(logic [15:0] p);
    if (tb_mode == 2'b10) return {p[15:5], p[4:0] + 5'd1};
    return p + 16'd1;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sclk(input logic [1:0] d, input bit desel, output logic [1:0] q, output logic [1:0] o);
    din = d;
    tick(6);
    q = dio_o;
    o = dio_oe;
    sck = 1'b1;
    if (desel) sel_n = 1'b1;
    tick(6);
    sck = 1'b0;
  endtask

  task automatic xbits(input logic [7:0] tx, input int nbits, input bit desel_last,
                       output logic [7:0] rx, output logic [1:0] oe_acc);
    logic [1:0] q, o;
    rx = '0;
    oe_acc = '0;
    if (tb_dual) begin
      for (int k = 3; k >= 0; k--) begin
        sclk({tx[2*k+1], tx[2*k]}, desel_last && k == 0, q, o);
        rx[2*k+1] = q[1];
        rx[2*k] = q[0];
        oe_acc |= o;
      end
    end else begin
      for (int i = 7; i >= 8 - nbits; i--) begin
        sclk({1'b0, tx[i]}, desel_last && i == 0, q, o);
        rx[i] = q[1];
        oe_acc |= o;
      end
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic [1:0] o);
    xbits(tx, 8, 1'b0, rx, o);
  endtask

  task automatic select();
    sel_n = 1'b0;
    tick(6);
  endtask

  task automatic deselect();
    sel_n = 1'b1;
    tick(8);
  endtask

  task automatic header(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] r;
    logic [1:0] o;
    xbyte(op, r, o);
    xbyte(a[15:8], r, o);
    xbyte(a[7:0], r, o);
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input int seed);
    logic [7:0] r;
    logic [1:0] o;
    logic [15:0] p;
    p = a;
    select();
    header(8'h02, a);
    for (int i = 0; i < n; i++) begin
      xbyte(pat(seed + i), r, o);
      if (tb_mode != 2'b00 || i == 0) mm[p[MAW-1:0]] = pat(seed + i);
      p = next_ptr(p);
    end
    deselect();
  endtask

  task automatic do_read(input string tag, input logic [15:0] a, input int n);
    logic [7:0] r;
    logic [1:0] o;
    logic [15:0] p;
    p = a;
    select();
    header(8'h03, a);
    if (tb_dual) begin
      xbyte(8'h00, r, o);
      chk({tag, " R11 dummy byte enables"}, o, 0);
    end
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, r, o);
      if (tb_mode == 2'b00 && i > 0) begin
        chk({tag, " R7 extra read clocks enables"}, o, 0);
      end else begin
        chk({tag, " data"}, r, mm[p[MAW-1:0]]);
        chk({tag, " R13 enables"}, o, tb_dual ? 3 : 2);
      end
      p = next_ptr(p);
    end
    deselect();
  endtask

  task automatic mode_wr(input logic [7:0] v);
    logic [7:0] r;
    logic [1:0] o;
    select();
    xbyte(8'h01, r, o);
    xbyte(v, r, o);
    deselect();
    tb_mode = v[7:6];
  endtask

  task automatic mode_chk(input string tag, input logic [7:0] exp);
    logic [7:0] r;
    logic [1:0] o;
    select();
    xbyte(8'h05, r, o);
    xbyte(8'h00, r, o);
    deselect();
    chk({tag, " mode value"}, r, exp);
    chk({tag, " mode enables"}, o, tb_dual ? 3 : 2);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [1:0] o;

    // reset while chip select is already low
    tick(5);
    rst = 1'b0;
    tick(4);
    chk("R1 enables after reset", dio_oe, 0);

    // R2: no high-to-low edge seen yet, a mode read must stay silent
    xbyte(8'h05, r, o);
    xbyte(8'h00, r, o);
    chk("R2 no command without select edge", o, 0);
    deselect();

    mode_chk("R1 reset mode R4", 8'h40);

    // R3/R5: full sequential sweep of the array
    do_write(16'h0000, DEPTH, 0);
    do_read("R3 R5 sequential sweep", 16'h0000, DEPTH);
    do_read("R5 wrap at 0xFFFF", 16'hFFFE, 4);

    // R4: low bits are not writable
    mode_wr(8'hFF);
    mode_chk("R4 masked write", 8'hC0);

    // R6: page wrap
    mode_wr(8'h80);
    do_write(16'h005E, 4, 100);
    do_read("R6 page wrap read", 16'h005D, 6);
    mode_wr(8'h40);
    do_read("R6 page contents", 16'h0040, 32);

    // R7: single byte per transaction
    mode_wr(8'h00);
    do_write(16'h0070, 3, 200);
    do_read("R7 byte mode read", 16'h0070, 3);
    mode_wr(8'h40);
    do_read("R7 neighbours intact", 16'h006F, 4);

    // R8: partial byte dropped
    select();
    header(8'h02, 16'h0090);
    xbyte(8'h5A, r, o);
    mm[8'h90] = 8'h5A;
    xbits(8'hC3, 5, 1'b0, r, o);
    deselect();
    do_read("R8 partial byte", 16'h0090, 2);

    // R9: last bit edge and deselect arrive together
    select();
    header(8'h02, 16'h00A0);
    xbits(8'h3C, 8, 1'b1, r, o);
    tick(8);
    mm[8'hA0] = 8'h3C;
    do_read("R9 coincident deselect", 16'h009F, 3);

    // R10: unknown opcode
    select();
    header(8'h77, 16'h0000);
    xbyte(8'h12, r, o);
    chk("R10 unknown opcode enables", o, 0);
    xbyte(8'h34, r, o);
    chk("R10 unknown opcode enables late", o, 0);
    deselect();
    mode_chk("R10 mode unchanged", 8'h40);
    do_read("R10 array unchanged", 16'h0000, 4);

    // R11: enter two-bit framing
    select();
    xbyte(8'h3B, r, o);
    deselect();
    tb_dual = 1'b1;
    do_write(16'h0010, 4, 50);
    do_read("R11 dual read", 16'h000F, 6);
    mode_chk("R11 dual mode read", 8'h40);

    // R12: leave two-bit framing using two-bit framing
    select();
    xbyte(8'hFF, r, o);
    deselect();
    tb_dual = 1'b0;
    do_read("R12 back to single", 16'h0010, 2);

    // R12: the exit opcode in one-bit framing is harmless
    select();
    xbyte(8'hFF, r, o);
    deselect();
    do_read("R12 exit from single", 16'h0012, 2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule